// File: doc/BRIEF.md
# Page-Aligned Flash Write Sequencer

This block turns a byte-granular access request (start address and length) into the page-level operations that a page-organised serial flash device expects. A write is cut into up to three kinds of segment: a partial page at the head when the start is not on a page boundary, a run of whole pages, and a partial page at the tail. A whole page is programmed with a single page-program command. A partial page goes through a read-modify-write in the device's internal SRAM buffer, which takes three commands. First the page is fetched into the buffer. Next the new bytes are filled in at the in-page offset. Last the buffer is committed back with an erase-and-program.

Each command is handed to a lower command framer through a valid/ready handshake, and the framer reports completion with a done pulse and an error flag. After every write command the sequencer asks a ready poller, through a request/done handshake, whether the device has finished its internal operation. Reads use the same path: they are cut into bounded chunks, and a ready poll comes before each chunk. A request is accepted whenever the block is idle. The outcome is reported by a one-cycle done pulse that carries a two-bit status code. The serial signalling itself lives in the framer and the poller, not here.

Top module: `flash_page_sequencer`

## Requirements
- R1: When start address plus length exceeds PAGE_BYTES times PAGE_COUNT, the request completes with status 1 (overflow) and issues no command and no ready poll. A request that ends exactly at that limit is accepted.
- R2: When the start address is not a multiple of PAGE_BYTES, the first segment covers min(PAGE_BYTES minus the in-page offset, length) bytes.
- R3: A partial page is handled by three commands in this order. Op 1 (page to buffer) carries the page, offset 0 and length 0. Op 2 (buffer fill) carries the page, the in-page offset and the segment length. Op 3 (buffer commit with erase) carries the page, offset 0 and length 0.
- R4: In a write, every command is followed by a ready poll, and the next command is issued only after that poll reports ready. The first command of a request needs no earlier poll.
- R5: While the cursor sits on a page boundary and at least PAGE_BYTES remain, one op 4 (page program) is issued with offset 0 and length PAGE_BYTES. The cursor then advances by one page.
- R6: Bytes left after the last whole page (fewer than PAGE_BYTES, starting on a boundary) are written as a partial page using the R3 sequence with offset 0.
- R7: A read is split into chunks of at most CHUNK_BYTES (32768 by default). Each chunk is one op 5 (stream read) carrying the chunk's page, in-page offset and length, and it is preceded by exactly one ready poll.
- R8: A command completed with the error flag set ends the request at once with status 2. No further command or poll follows.
- R9: A ready poll that finishes with the ready flag low ends the request at once with status 3. No further command follows.
- R10: After reset the block is idle with busy, done, cmd_valid and poll_req low. Busy is high from the cycle after acceptance until done. Done is a one-cycle pulse. A zero-length request completes with status 0 and issues nothing.
- R11: The segments of a request are contiguous in address and add up exactly to the requested length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_read | input | 1 | 1 = read request, 0 = write request |
| req_addr | input | AW | Byte start address |
| req_len | input | LW | Byte length |
| busy | output | 1 | A request is in progress |
| cmd_valid | output | 1 | Command offered to the framer |
| cmd_ready | input | 1 | Framer takes the command |
| cmd_op | output | 3 | 1 fetch, 2 fill, 3 commit, 4 page program, 5 stream read |
| cmd_page | output | PG_W | Target page index |
| cmd_offset | output | OFF_W | Byte offset in the page |
| cmd_len | output | LW | Data bytes carried by the command |
| cmd_done | input | 1 | Framer finished the accepted command |
| cmd_err | input | 1 | Qualifies cmd_done as failed |
| poll_req | output | 1 | Ready poll requested, held until poll_done |
| poll_done | input | 1 | Poller finished |
| poll_ok | input | 1 | Qualifies poll_done: device ready |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 overflow, 2 command error, 3 not ready |

## Verification
The bench goes after the segment boundaries: an unaligned start whose head is clipped by a short length, a head that runs exactly to the page end, a tail left on an aligned page, and a request ending exactly at the capacity limit. A design that mishandled these would issue a fill that crosses into the next page, a page program with a non-zero offset, or a false overflow rejection. Reads that cross the chunk limit show whether chunks are clipped and whether a poll comes before each of them. Failures injected at a chosen command or poll show whether the sequencer stops at once, or instead carries on with later pages or reports the wrong code.

// File: rtl/fsp_pkg.sv
`timescale 1ns/1ps
package fsp_pkg;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_PAGE_TO_BUF = 3'd1,
    OP_BUF_FILL    = 3'd2,
    OP_BUF_COMMIT  = 3'd3,
    OP_PAGE_PROG   = 3'd4,
    OP_STREAM_READ = 3'd5
  } flash_op_e;

  typedef enum logic [1:0] {
    ST_OK        = 2'd0,
    ST_OVERFLOW  = 2'd1,
    ST_CMD_ERR   = 2'd2,
    ST_NOT_READY = 2'd3
  } seq_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_ISSUE, S_WAIT_CMD, S_POLL, S_FIN
  } seq_state_e;

  function automatic longint unsigned page_of(input longint unsigned addr,
                                              input longint unsigned page_bytes);
    return addr / page_bytes;
  endfunction

  function automatic longint unsigned offset_in(input longint unsigned addr,
                                                input longint unsigned page_bytes);
    return addr % page_bytes;
  endfunction

  // bytes from the in-page offset to the page end, limited by what is left
  function automatic longint unsigned head_span(input longint unsigned off,
                                                input longint unsigned remain,
                                                input longint unsigned page_bytes);
    longint unsigned room;
    room = page_bytes - off;
    return (remain < room) ? remain : room;
  endfunction

  function automatic longint unsigned clip(input longint unsigned val,
                                           input longint unsigned limit);
    return (val < limit) ? val : limit;
  endfunction

  function automatic logic beyond_end(input longint unsigned addr,
                                      input longint unsigned len,
                                      input longint unsigned cap);
    return (addr + len) > cap;
  endfunction

endpackage

// File: rtl/fsp_range_check.sv
`timescale 1ns/1ps
module fsp_range_check #(
  parameter int AW = 24,
  parameter int LW = 24,
  parameter longint unsigned CAP_BYTES = 64'd67584
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] len,
  output logic          overflow
);
  assign overflow = fsp_pkg::beyond_end(64'(addr), 64'(len), CAP_BYTES);
endmodule

// File: rtl/fsp_span_planner.sv
`timescale 1ns/1ps
module fsp_span_planner #(
  parameter int AW          = 24,
  parameter int LW          = 24,
  parameter int PAGE_BYTES  = 264,
  parameter int CHUNK_BYTES = 32768,
  parameter int PG_W        = 8,
  parameter int OFF_W       = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_mode,
  input  logic [AW-1:0]    cur_addr,
  input  logic [LW-1:0]    remain,
  output logic [PG_W-1:0]  page_idx,
  output logic [OFF_W-1:0] page_off,
  output logic [LW-1:0]    seg_len,
  output logic             partial
);
  import fsp_pkg::*;

  localparam longint unsigned PB_L = 64'(PAGE_BYTES);
  localparam longint unsigned CH_L = 64'(CHUNK_BYTES);

  logic [63:0] a_l, r_l, off_l, seg_l;

  always_comb begin
    a_l   = 64'(cur_addr);
    r_l   = 64'(remain);
    off_l = offset_in(a_l, PB_L);
    if (rd_mode) begin
      seg_l   = clip(r_l, CH_L);
      partial = 1'b0;
    end else if (off_l != 64'd0 || r_l < PB_L) begin
      seg_l   = head_span(off_l, r_l, PB_L);
      partial = 1'b1;
    end else begin
      seg_l   = PB_L;
      partial = 1'b0;
    end
    page_idx = PG_W'(page_of(a_l, PB_L));
    page_off = OFF_W'(off_l);
    seg_len  = LW'(seg_l);
  end

  // R2: a partial write segment never runs past its page end
  a_r2_head_fits_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_mode && partial && remain != '0) |->
      (64'(page_off) + 64'(seg_len) <= PB_L && seg_len != '0));

endmodule

// File: rtl/fsp_cursor.sv
`timescale 1ns/1ps
module fsp_cursor #(
  parameter int AW = 24,
  parameter int LW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [LW-1:0] load_len,
  input  logic          adv,
  input  logic [LW-1:0] step_len,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] remain
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      remain   <= load_len;
    end else if (adv) begin
      cur_addr <= cur_addr + AW'(step_len);
      remain   <= remain - step_len;
    end
  end

  // R11: every step consumes bytes that are still owed, never more
  a_r11_step_within_remain: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (step_len != '0 && step_len <= remain));

endmodule

// File: rtl/flash_page_sequencer.sv
`timescale 1ns/1ps
module flash_page_sequencer
  import fsp_pkg::*;
#(
  parameter int PAGE_BYTES  = 264,
  parameter int PAGE_COUNT  = 256,
  parameter int AW          = 24,
  parameter int LW          = 24,
  parameter int CHUNK_BYTES = 32768,
  localparam int PG_W  = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1,
  localparam int OFF_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_read,
  input  logic [AW-1:0]    req_addr,
  input  logic [LW-1:0]    req_len,
  output logic             busy,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [2:0]       cmd_op,
  output logic [PG_W-1:0]  cmd_page,
  output logic [OFF_W-1:0] cmd_offset,
  output logic [LW-1:0]    cmd_len,
  input  logic             cmd_done,
  input  logic             cmd_err,
  output logic             poll_req,
  input  logic             poll_done,
  input  logic             poll_ok,
  output logic             done,
  output logic [1:0]       status
);

  localparam longint unsigned CAP_L = 64'(PAGE_BYTES) * 64'(PAGE_COUNT);

  seq_state_e  state_q, state_d;
  seq_status_e status_q;
  logic             mode_rd_q, partial_q;
  logic [1:0]       step_q;
  logic [PG_W-1:0]  page_q;
  logic [OFF_W-1:0] off_q;
  logic [LW-1:0]    seg_q;

  // named events
  logic accept, range_bad, plan_empty, cmd_fire, cmd_ok, cmd_bad;
  logic poll_pass, poll_fail, last_step, seg_adv;

  logic [AW-1:0]    cur_addr;
  logic [LW-1:0]    remain;
  logic [PG_W-1:0]  plan_page;
  logic [OFF_W-1:0] plan_off;
  logic [LW-1:0]    plan_seg;
  logic             plan_partial;
  flash_op_e        op_sel;

  fsp_range_check #(.AW(AW), .LW(LW), .CAP_BYTES(CAP_L)) u_range (
    .addr(req_addr), .len(req_len), .overflow(range_bad));

  fsp_cursor #(.AW(AW), .LW(LW)) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_addr(req_addr), .load_len(req_len),
    .adv(seg_adv), .step_len(seg_q),
    .cur_addr(cur_addr), .remain(remain));

  fsp_span_planner #(
    .AW(AW), .LW(LW), .PAGE_BYTES(PAGE_BYTES), .CHUNK_BYTES(CHUNK_BYTES),
    .PG_W(PG_W), .OFF_W(OFF_W)
  ) u_plan (
    .clk(clk), .rst_n(rst_n), .rd_mode(mode_rd_q),
    .cur_addr(cur_addr), .remain(remain),
    .page_idx(plan_page), .page_off(plan_off),
    .seg_len(plan_seg), .partial(plan_partial));

  assign accept     = (state_q == S_IDLE) && req_valid;
  assign plan_empty = (remain == '0);
  assign cmd_fire   = cmd_valid && cmd_ready;
  assign cmd_ok     = (state_q == S_WAIT_CMD) && cmd_done && !cmd_err;
  assign cmd_bad    = (state_q == S_WAIT_CMD) && cmd_done && cmd_err;
  assign poll_pass  = (state_q == S_POLL) && poll_done && poll_ok;
  assign poll_fail  = (state_q == S_POLL) && poll_done && !poll_ok;
  assign last_step  = !partial_q || (step_q == 2'd2);
  assign seg_adv    = (cmd_ok && mode_rd_q) ||
                      (poll_pass && !mode_rd_q && last_step);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:     if (accept) state_d = range_bad ? S_FIN : S_PLAN;
      S_PLAN:     state_d = plan_empty ? S_FIN : (mode_rd_q ? S_POLL : S_ISSUE);
      S_ISSUE:    if (cmd_ready) state_d = S_WAIT_CMD;
      S_WAIT_CMD: begin
        if (cmd_bad)     state_d = S_FIN;
        else if (cmd_ok) state_d = mode_rd_q ? S_PLAN : S_POLL;
      end
      S_POLL: begin
        if (poll_fail)      state_d = S_FIN;
        else if (poll_pass) state_d = (mode_rd_q || !last_step) ? S_ISSUE : S_PLAN;
      end
      S_FIN:      state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      status_q  <= ST_OK;
      mode_rd_q <= 1'b0;
      partial_q <= 1'b0;
      step_q    <= 2'd0;
      page_q    <= '0;
      off_q     <= '0;
      seg_q     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        mode_rd_q <= req_read;
        status_q  <= range_bad ? ST_OVERFLOW : ST_OK;
      end
      if (state_q == S_PLAN && !plan_empty) begin
        page_q    <= plan_page;
        off_q     <= plan_off;
        seg_q     <= plan_seg;
        partial_q <= plan_partial;
        step_q    <= 2'd0;
      end
      if (poll_pass && !mode_rd_q && !last_step) step_q <= step_q + 2'd1;
      if (cmd_bad)   status_q <= ST_CMD_ERR;
      if (poll_fail) status_q <= ST_NOT_READY;
    end
  end

  // command decode from the latched segment and the step index
  always_comb begin
    op_sel     = OP_NONE;
    cmd_offset = '0;
    cmd_len    = '0;
    if (state_q == S_ISSUE) begin
      if (mode_rd_q) begin
        op_sel     = OP_STREAM_READ;
        cmd_offset = off_q;
        cmd_len    = seg_q;
      end else if (!partial_q) begin
        op_sel  = OP_PAGE_PROG;
        cmd_len = seg_q;
      end else begin
        case (step_q)
          2'd0: op_sel = OP_PAGE_TO_BUF;
          2'd1: begin
            op_sel     = OP_BUF_FILL;
            cmd_offset = off_q;
            cmd_len    = seg_q;
          end
          default: op_sel = OP_BUF_COMMIT;
        endcase
      end
    end
  end

  assign cmd_valid = (state_q == S_ISSUE);
  assign cmd_op    = op_sel;
  assign cmd_page  = page_q;
  assign poll_req  = (state_q == S_POLL);
  assign done      = (state_q == S_FIN);
  assign status    = status_q;
  assign busy      = (state_q != S_IDLE);

  // ---------------- assertion bookkeeping ----------------
  flash_op_e last_op_q;
  logic      owe_poll_q, polled_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_op_q  <= OP_NONE;
      owe_poll_q <= 1'b0;
      polled_q   <= 1'b0;
    end else begin
      if (accept)        last_op_q <= OP_NONE;
      else if (cmd_fire) last_op_q <= op_sel;
      if (accept)                     owe_poll_q <= 1'b0;
      else if (cmd_ok && !mode_rd_q)  owe_poll_q <= 1'b1;
      else if (poll_pass)             owe_poll_q <= 1'b0;
      if (accept)         polled_q <= 1'b0;
      else if (poll_pass) polled_q <= 1'b1;
      else if (cmd_fire)  polled_q <= 1'b0;
    end
  end

  // R1: an overflow verdict is reached straight from idle, with nothing issued
  a_r1_no_overflow_ops: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FIN && status_q == ST_OVERFLOW) |-> ($past(state_q) == S_IDLE));

  // R3: fill follows fetch, commit follows fill
  a_r3_fill_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op_sel == OP_BUF_FILL) |-> (last_op_q == OP_PAGE_TO_BUF));
  a_r3_commit_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && op_sel == OP_BUF_COMMIT) |-> (last_op_q == OP_BUF_FILL));

  // R4: no write command while a ready poll is still owed
  a_r4_poll_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !owe_poll_q);

  // R5: whole-page program is page aligned and page sized
  a_r5_full_page_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op_sel == OP_PAGE_PROG) |->
      (cmd_offset == '0 && cmd_len == LW'(PAGE_BYTES)));

  // R7: read chunks bounded, non-empty and preceded by a poll
  a_r7_read_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op_sel == OP_STREAM_READ) |->
      (cmd_len != '0 && cmd_len <= LW'(CHUNK_BYTES) && polled_q));

  // R8 / R9: failures end the request on the next cycle
  a_r8_abort_on_cmd_err: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |=> (done && status == ST_CMD_ERR));
  a_r9_abort_on_poll_fail: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fail |=> (done && status == ST_NOT_READY));

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/flash_page_sequencer_test.sv
`timescale 1ns/1ps
module flash_page_sequencer_test;

  localparam int P     = 264;
  localparam int N     = 256;
  localparam int AW    = 24;
  localparam int LW    = 24;
  localparam int CH    = 32768;
  localparam int PG_W  = 8;
  localparam int OFF_W = 9;
  localparam int CAP   = P * N;

  logic clk, rst_n;
  logic req_valid, req_read;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic busy, cmd_valid, cmd_ready, cmd_done, cmd_err;
  logic [2:0] cmd_op;
  logic [PG_W-1:0] cmd_page;
  logic [OFF_W-1:0] cmd_offset;
  logic [LW-1:0] cmd_len;
  logic poll_req, poll_done, poll_ok, done;
  logic [1:0] status;

  flash_page_sequencer #(
    .PAGE_BYTES(P), .PAGE_COUNT(N), .AW(AW), .LW(LW), .CHUNK_BYTES(CH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_len(req_len), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .cmd_offset(cmd_offset), .cmd_len(cmd_len),
    .cmd_done(cmd_done), .cmd_err(cmd_err),
    .poll_req(poll_req), .poll_done(poll_done), .poll_ok(poll_ok),
    .done(done), .status(status));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    bit is_cmd;
    int op;
    int page;
    int off;
    int len;
  } ev_t;

  ev_t   ev_q[$];
  ev_t   exp_q[$];
  ev_t   got_e;
  int    errors = 0, checks = 0;
  int    exp_status, got_status;
  int    fail_cmd_at = -1, fail_poll_at = -1, cmd_n = 0, poll_n = 0;
  int    polls_seen = 0;
  bit    first_cmd = 1'b1, got_done = 1'b0, cur_rd = 1'b0;
  string tag = "R10";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // page and offset by repeated subtraction
  task automatic locate(input int a, output int pg, output int of);
    pg = 0;
    of = a;
    while (of >= P) begin
      of -= P;
      pg++;
    end
  endtask

  task automatic push(input bit c, input int op, input int pg, input int of, input int ln);
    ev_t e;
    e.is_cmd = c; e.op = op; e.page = pg; e.off = of; e.len = ln;
    ev_q.push_back(e);
  endtask

  task automatic plan_write(input int a0, input int r0);
    int a = a0, r = r0, pg, of, n;
    while (r > 0) begin
      locate(a, pg, of);
      if (of != 0 || r < P) begin
        n = P - of;
        if (n > r) n = r;
        push(1, 1, pg, 0, 0);  push(0, 0, 0, 0, 0);
        push(1, 2, pg, of, n); push(0, 0, 0, 0, 0);
        push(1, 3, pg, 0, 0);  push(0, 0, 0, 0, 0);
      end else begin
        n = P;
        push(1, 4, pg, 0, P);  push(0, 0, 0, 0, 0);
      end
      a += n;
      r -= n;
    end
  endtask

  task automatic plan_read(input int a0, input int r0);
    int a = a0, r = r0, pg, of, n;
    while (r > 0) begin
      n = (r > CH) ? CH : r;
      locate(a, pg, of);
      push(0, 0, 0, 0, 0);
      push(1, 5, pg, of, n);
      a += n;
      r -= n;
    end
  endtask

  task automatic run(input int a, input int ln, input bit rd, input int fc,
                     input int fp, input string t);
    int ci = 0, pi = 0, guard = 0;
    ev_q.delete();
    exp_q.delete();
    exp_status = 0;
    if (a + ln > CAP) exp_status = 1;
    else begin
      if (rd) plan_read(a, ln);
      else    plan_write(a, ln);
      for (int k = 0; k < ev_q.size(); k++) begin
        if (ev_q[k].is_cmd) begin
          exp_q.push_back(ev_q[k]);
          if (ci == fc) begin exp_status = 2; break; end
          ci++;
        end else begin
          if (pi == fp) begin exp_status = 3; break; end
          pi++;
        end
      end
    end
    while (busy) @(negedge clk);
    fail_cmd_at = fc; fail_poll_at = fp; cmd_n = 0; poll_n = 0;
    tag = t; got_done = 1'b0; polls_seen = 0; first_cmd = 1'b1; cur_rd = rd;
    @(posedge clk);
    #1 req_valid = 1'b1; req_read = rd; req_addr = AW'(a); req_len = LW'(ln);
    @(posedge clk);
    #1 req_valid = 1'b0;
    check(busy == 1'b1, "R10", "busy after accept", int'(busy), 1);
    while (!got_done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(got_done, t, "watchdog done", int'(got_done), 1);
    check(got_status == exp_status, t, "status", got_status, exp_status);
    check(exp_q.size() == 0, t, "commands still owed", exp_q.size(), 0);
  endtask

  // command framer model
  initial begin
    cmd_ready = 1'b0; cmd_done = 1'b0; cmd_err = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (cmd_valid) begin
        repeat (cmd_n % 3) @(posedge clk);
        #1 cmd_ready = 1'b1;
        @(posedge clk);
        #1 cmd_ready = 1'b0;
        repeat ((cmd_n + 1) % 4) @(posedge clk);
        #1 cmd_done = 1'b1;
        cmd_err = (cmd_n == fail_cmd_at);
        cmd_n++;
        @(posedge clk);
        #1 cmd_done = 1'b0; cmd_err = 1'b0;
      end
    end
  end

  // ready poller model
  initial begin
    poll_done = 1'b0; poll_ok = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      if (poll_req) begin
        repeat (poll_n % 4 + 1) @(posedge clk);
        #1 poll_done = 1'b1;
        poll_ok = (poll_n != fail_poll_at);
        poll_n++;
        @(posedge clk);
        #1 poll_done = 1'b0; poll_ok = 1'b0;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (poll_req && poll_done) polls_seen++;
      if (cmd_valid && cmd_ready) begin
        if (cur_rd) check(polls_seen == 1, "R7", "polls before chunk", polls_seen, 1);
        else check(polls_seen == (first_cmd ? 0 : 1), "R4", "polls before command",
                   polls_seen, first_cmd ? 0 : 1);
        polls_seen = 0;
        first_cmd  = 1'b0;
        if (exp_q.size() == 0) check(1'b0, tag, "unexpected command op", int'(cmd_op), 0);
        else begin
          got_e = exp_q.pop_front();
          checks++;
          if (int'(cmd_op) != got_e.op || int'(cmd_page) != got_e.page ||
              int'(cmd_offset) != got_e.off || int'(cmd_len) != got_e.len) begin
            errors++;
            $display("FAIL %s R11 command: got op=%0d page=%0d off=%0d len=%0d expected op=%0d page=%0d off=%0d len=%0d",
                     tag, cmd_op, cmd_page, cmd_offset, cmd_len,
                     got_e.op, got_e.page, got_e.off, got_e.len);
          end
        end
      end
      if (done) begin
        got_done   = 1'b1;
        got_status = int'(status);
      end
    end
  end

  // global watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got expired expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_addr = '0; req_len = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !cmd_valid && !poll_req, "R10", "reset idle outputs",
          int'({busy, done, cmd_valid, poll_req}), 0);

    run(3 * P, P, 0, -1, -1, "R5");                              // one whole page
    run(5 * P + 100, (P - 100) + 2 * P + 50, 0, -1, -1, "R11");  // head, run, tail
    run(10, 20, 0, -1, -1, "R2");                                // clipped head
    run(2 * P + 200, P, 0, -1, -1, "R3");                        // head to page end then tail
    run(7 * P, 30, 0, -1, -1, "R6");                             // aligned tail only
    run(20 * P + 5, 600, 0, -1, -1, "R4");
    run(CAP - 10, 11, 0, -1, -1, "R1");                          // one byte too far
    run(CAP - 10, 10, 0, -1, -1, "R1");                          // ends exactly at limit
    run(CAP - 5, 100, 1, -1, -1, "R1");                          // read overflow
    run(40, 0, 0, -1, -1, "R10");                                // zero-length write
    run(100, 0, 1, -1, -1, "R10");                               // zero-length read
    run(0, 40000, 1, -1, -1, "R7");                              // two chunks
    run(300, 100, 1, -1, -1, "R7");                              // unaligned read
    run(4 * P + 10, 3 * P, 0, 2, -1, "R8");                      // commit fails
    run(P, 2 * P, 0, -1, 0, "R9");                               // first poll not ready
    run(0, 40000, 1, -1, 1, "R9");                               // second chunk poll fails
    run(6 * P, 2 * P, 0, -1, -1, "R5");                          // recovers after aborts

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule